// File: doc/BRIEF.md
# Pipelined Longest-Match Selector

This block sits between a bank of parallel dictionary lanes and the token encoder of a streaming byte compressor. On every clock it receives one set of candidate results, one result per lane. Each result carries a hit flag, a match length and a back-reference distance (offset). A per-lane enable mask says which lanes take part in the current set. The block reduces the set to a single winner through a balanced binary tree of registered two-way compares. The winner is the eligible candidate with the longest match. It hands the winner's length, offset and lane position (lane index, which equals its position in the scan window) to the encoder.

The tree has one register level per halving. With sixteen lanes the latency is therefore fixed at four cycles. A new set is accepted every cycle and nothing ever stalls. A set-valid flag travels down a shift register beside the data. When no lane offers a usable match, the output marks the set as literal-only so that the encoder emits its bytes uncompressed.

Top module: `lmsel_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), and until the first set accepted after reset emerges, `out_valid`, `out_match`, `out_len`, `out_ofs` and `out_pos` are all 0. A reset in mid-stream discards every set in flight.
- R2: A set presented with `in_valid`=1 at a rising edge produces its result on the outputs after the fourth rising edge, counting that edge as the first. Sets may be presented on every consecutive cycle without any stall.
- R3: The winner is the eligible lane with the largest match length.
- R4: `out_ofs` equals the offset input of the winning lane, and `out_pos` equals that lane's index (0 to 15, 4 bits). Lane k occupies bits [5k+4:5k] of `lane_len` and bits [16k+15:16k] of `lane_ofs`.
- R5: When several eligible lanes share the largest length, the lane with the lowest index wins.
- R6: A lane whose bit in `lane_work` is 0 is never selected, whatever its hit flag and length.
- R7: A lane whose bit in `lane_hit` is 0 is never selected, whatever its length.
- R8: Only lengths of at least 4 are eligible. A length of 3 never wins and a length of 4 can. With no eligible lane, `out_match` is 0 and `out_len`, `out_ofs` and `out_pos` are all 0.
- R9: For a set presented with `in_valid`=0, the corresponding output cycle has `out_valid`=0 and `out_match`=0, with all fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A candidate set is present this cycle |
| lane_hit | input | 16 | Per-lane hit flag, bit k for lane k |
| lane_work | input | 16 | Per-lane enable mask, bit k for lane k |
| lane_len | input | 80 | Match lengths, 5 bits per lane, lane k at [5k+4:5k] |
| lane_ofs | input | 256 | Offsets, 16 bits per lane, lane k at [16k+15:16k] |
| out_valid | output | 1 | Result of a valid set is present |
| out_match | output | 1 | A usable match was found (0 means literal-only) |
| out_len | output | 5 | Winning match length |
| out_ofs | output | 16 | Winning offset |
| out_pos | output | 4 | Winning lane index |

## Verification
A table of hand-built sets separates the selection rules from one another. Each set has a single long lane placed among short ones. Other sets have ties between two lanes and a full sixteen-way tie, which expose a reversed tie-break. In further sets the longest length sits on a disabled lane or on a lane without a hit, which shows whether masking happens before the compare. Sets at lengths 3 and 4 pin the minimum-length threshold. Idle cycles loaded with long hits must give no result, and a reset in mid-stream must flush the tree. A long run of random sets, some with lengths in a narrow range so that ties and sub-threshold values are common, is then compared with a plain linear maximum search delayed by four cycles. That comparison catches errors in pipeline alignment and in offset routing.

// File: rtl/lmsel_pkg.sv
package lmsel_pkg;
    parameter int LANES   = 16;
    parameter int LEN_W   = 5;
    parameter int OFS_W   = 16;
    parameter int MIN_LEN = 4;
    parameter int POS_W   = $clog2(LANES);
    parameter int STAGES  = $clog2(LANES);

    typedef struct packed {
        logic             hit;
        logic [LEN_W-1:0] len;
        logic [OFS_W-1:0] ofs;
        logic [POS_W-1:0] pos;
    } cand_t;
endpackage

// File: rtl/lmsel_qual.sv
module lmsel_qual
    import lmsel_pkg::*;
#(
    parameter int LANE_ID = 0
) (
    input  logic             set_vld,
    input  logic             hit,
    input  logic             work,
    input  logic [LEN_W-1:0] len,
    input  logic [OFS_W-1:0] ofs,
    output cand_t            cand
);
    logic elig;

    always_comb begin
        elig = set_vld && hit && work && (len >= LEN_W'(MIN_LEN));
        cand = '0;
        if (elig) begin
            cand.hit = 1'b1;
            cand.len = len;
            cand.ofs = ofs;
            cand.pos = POS_W'(LANE_ID);
        end
    end
endmodule

// File: rtl/lmsel_pick.sv
module lmsel_pick
    import lmsel_pkg::*;
(
    input  cand_t lo,
    input  cand_t hi,
    output cand_t win
);
    // lo holds the lower lane indices; it keeps the win on equal length
    always_comb begin
        if (hi.hit && (!lo.hit || (hi.len > lo.len))) begin
            win = hi;
        end else begin
            win = lo;
        end
    end
endmodule

// File: rtl/lmsel_top.sv
module lmsel_top
    import lmsel_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES-1:0]       lane_hit,
    input  logic [LANES-1:0]       lane_work,
    input  logic [LANES*LEN_W-1:0] lane_len,
    input  logic [LANES*OFS_W-1:0] lane_ofs,
    output logic                   out_valid,
    output logic                   out_match,
    output logic [LEN_W-1:0]       out_len,
    output logic [OFS_W-1:0]       out_ofs,
    output logic [POS_W-1:0]       out_pos
);
    // Heap-ordered tree: node i has children 2i and 2i+1.
    // Indices LANES..2*LANES-1 are the qualified lanes (leaf).
    cand_t [LANES-1:0] leaf;
    cand_t [LANES-1:1] nxt;
    cand_t [LANES-1:1] node_q;
    logic  [STAGES-1:0] vld_q;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            lmsel_qual #(.LANE_ID(k)) u_qual (
                .set_vld (in_valid),
                .hit     (lane_hit[k]),
                .work    (lane_work[k]),
                .len     (lane_len[k*LEN_W +: LEN_W]),
                .ofs     (lane_ofs[k*OFS_W +: OFS_W]),
                .cand    (leaf[k])
            );
        end

        for (k = 1; k < LANES; k++) begin : g_node
            if (2*k >= LANES) begin : g_from_leaf
                lmsel_pick u_pick (
                    .lo  (leaf[2*k - LANES]),
                    .hi  (leaf[2*k + 1 - LANES]),
                    .win (nxt[k])
                );
            end else begin : g_from_node
                lmsel_pick u_pick (
                    .lo  (node_q[2*k]),
                    .hi  (node_q[2*k + 1]),
                    .win (nxt[k])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            node_q <= '0;
            vld_q  <= '0;
        end else begin
            node_q <= nxt;
            vld_q  <= {vld_q[STAGES-2:0], in_valid};
        end
    end

    always_comb begin
        out_valid = vld_q[STAGES-1];
        out_match = node_q[1].hit;
        out_len   = node_q[1].len;
        out_ofs   = node_q[1].ofs;
        out_pos   = node_q[1].pos;
    end
endmodule

// File: rtl/lmsel_chk.sv
module lmsel_chk
    import lmsel_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [LANES-1:0] lane_hit,
    input logic [LANES-1:0] lane_work,
    input logic             out_valid,
    input logic             out_match,
    input logic [LEN_W-1:0] out_len,
    input logic [OFS_W-1:0] out_ofs,
    input logic [POS_W-1:0] out_pos
);
    logic [STAGES-1:0] set_pipe;
    logic [STAGES-1:0] any_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_pipe <= '0;
            any_pipe <= '0;
        end else begin
            set_pipe <= {set_pipe[STAGES-2:0], in_valid};
            any_pipe <= {any_pipe[STAGES-2:0], in_valid && ((lane_hit & lane_work) != '0)};
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == set_pipe[STAGES-1]);

    // R6 and R7: no lane with both hit and work set means no match
    a_r6_masked_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pipe[STAGES-1] |-> !out_match);

    a_r9_match_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |-> out_valid);

    a_r8_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        out_match |-> (out_len >= LEN_W'(MIN_LEN)));

    a_r8_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !out_match |-> (out_len == '0 && out_ofs == '0 && out_pos == '0));
endmodule

bind lmsel_top lmsel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .lane_hit  (lane_hit),
    .lane_work (lane_work),
    .out_valid (out_valid),
    .out_match (out_match),
    .out_len   (out_len),
    .out_ofs   (out_ofs),
    .out_pos   (out_pos)
);

// File: tb/lmsel_top_tb.sv
module lmsel_top_tb_top;
    import lmsel_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                   rst_n;
    logic                   in_valid;
    logic [LANES-1:0]       lane_hit;
    logic [LANES-1:0]       lane_work;
    logic [LANES*LEN_W-1:0] lane_len;
    logic [LANES*OFS_W-1:0] lane_ofs;
    logic                   out_valid;
    logic                   out_match;
    logic [LEN_W-1:0]       out_len;
    logic [OFS_W-1:0]       out_ofs;
    logic [POS_W-1:0]       out_pos;

    lmsel_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .lane_hit(lane_hit), .lane_work(lane_work),
        .lane_len(lane_len), .lane_ofs(lane_ofs),
        .out_valid(out_valid), .out_match(out_match),
        .out_len(out_len), .out_ofs(out_ofs), .out_pos(out_pos)
    );

    typedef struct packed {
        logic             v;
        logic             m;
        logic [LEN_W-1:0] len;
        logic [OFS_W-1:0] ofs;
        logic [POS_W-1:0] pos;
    } res_t;

    typedef struct packed {
        logic [15:0] hit;
        logic [15:0] work;
        logic [4:0]  fill;
        logic [4:0]  len_a;
        logic [3:0]  lane_a;
        logic [4:0]  len_b;
        logic [3:0]  lane_b;
        logic        exp_m;
        logic [4:0]  exp_len;
        logic [3:0]  exp_pos;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{16'hFFFF, 16'hFFFF, 5'd2,  5'd9,  4'd7,  5'd6,  4'd12, 1'b1, 5'd9,  4'd7},
        '{16'hFFFF, 16'hFFFF, 5'd5,  5'd20, 4'd3,  5'd20, 4'd9,  1'b1, 5'd20, 4'd3},
        '{16'hFFFF, 16'hFFFF, 5'd10, 5'd10, 4'd0,  5'd10, 4'd15, 1'b1, 5'd10, 4'd0},
        '{16'hFFFF, 16'h7FFF, 5'd4,  5'd31, 4'd15, 5'd8,  4'd2,  1'b1, 5'd8,  4'd2},
        '{16'hFFDF, 16'hFFFF, 5'd3,  5'd30, 4'd5,  5'd4,  4'd14, 1'b1, 5'd4,  4'd14},
        '{16'hFFFF, 16'hFFFF, 5'd3,  5'd3,  4'd6,  5'd0,  4'd1,  1'b0, 5'd0,  4'd0},
        '{16'hFFFF, 16'h0000, 5'd25, 5'd31, 4'd4,  5'd31, 4'd8,  1'b0, 5'd0,  4'd0},
        '{16'h0000, 16'hFFFF, 5'd31, 5'd31, 4'd2,  5'd31, 4'd3,  1'b0, 5'd0,  4'd0},
        '{16'hFFFF, 16'hFFFF, 5'd0,  5'd31, 4'd15, 5'd30, 4'd14, 1'b1, 5'd31, 4'd15},
        '{16'hFFFF, 16'hFFFF, 5'd4,  5'd4,  4'd0,  5'd4,  4'd1,  1'b1, 5'd4,  4'd0}
    };

    localparam int NBUB   = 3;
    localparam int NRAND  = 160;
    localparam int NSTEP  = NVEC + NBUB + NRAND + 4;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 0;

    res_t  exp_r   [8];
    string exp_tag [8];

    function automatic string vec_tag(int i);
        case (i)
            0: return "R3";
            1: return "R5";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            6: return "R6";
            7: return "R7";
            8: return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [OFS_W-1:0] ofs_of(int step, int lane);
        return OFS_W'((step * 16 + lane) ^ 'h5A00);
    endfunction

    // plain linear maximum search, lowest lane kept on equal length
    function automatic res_t ref_pick(logic v, logic [LANES-1:0] h, logic [LANES-1:0] w,
                                      logic [LANES*LEN_W-1:0] lens, int step);
        res_t best = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [LEN_W-1:0] l = lens[i*LEN_W +: LEN_W];
            if (v && h[i] && w[i] && l >= LEN_W'(MIN_LEN) && (!best.m || l > best.len)) begin
                best.m   = 1'b1;
                best.len = l;
                best.pos = POS_W'(i);
            end
        end
        best.v = v;
        if (best.m) best.ofs = ofs_of(step, int'(best.pos));
        return best;
    endfunction

    task automatic check(res_t e, string tag);
        res_t a;
        a = '{out_valid, out_match, out_len, out_ofs, out_pos};
        n_chk++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s: actual v=%0d m=%0d len=%0d ofs=%h pos=%0d expected v=%0d m=%0d len=%0d ofs=%h pos=%0d",
                     tag, a.v, a.m, a.len, a.ofs, a.pos, e.v, e.m, e.len, e.ofs, e.pos);
        end
    endtask

    task automatic drive(logic v, logic [LANES-1:0] h, logic [LANES-1:0] w,
                         logic [LANES*LEN_W-1:0] lens, int step);
        in_valid  = v;
        lane_hit  = h;
        lane_work = w;
        lane_len  = lens;
        for (int i = 0; i < LANES; i++) lane_ofs[i*OFS_W +: OFS_W] = ofs_of(step, i);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_err++;
            n_chk++;
            $display("FAIL R2 watchdog: actual cycles=%0d expected below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        res_t zero_r = '0;
        logic [LANES*LEN_W-1:0] lens;
        rst_n = 1'b0;
        drive(1'b0, '0, '0, '0, 0);
        for (int i = 0; i < 8; i++) begin
            exp_r[i]   = '0;
            exp_tag[i] = "R1";
        end
        repeat (3) @(negedge clk);
        check(zero_r, "R1");
        rst_n = 1'b1;

        for (int j = 0; j < NSTEP; j++) begin
            res_t e;
            string tg;
            logic v;
            logic [LANES-1:0] h, w;
            @(negedge clk);
            check(exp_r[(j + 4) % 8], exp_tag[(j + 4) % 8]);
            if (j < NVEC) begin
                vec_t t = VECS[j];
                for (int i = 0; i < LANES; i++) lens[i*LEN_W +: LEN_W] = t.fill;
                lens[int'(t.lane_a)*LEN_W +: LEN_W] = t.len_a;
                lens[int'(t.lane_b)*LEN_W +: LEN_W] = t.len_b;
                v = 1'b1; h = t.hit; w = t.work;
                e = '0;
                e.v = 1'b1;
                if (t.exp_m) begin
                    e.m = 1'b1; e.len = t.exp_len; e.pos = t.exp_pos;
                    e.ofs = ofs_of(j, int'(t.exp_pos));
                end
                tg = vec_tag(j);
            end else if (j < NVEC + NBUB) begin
                for (int i = 0; i < LANES; i++) lens[i*LEN_W +: LEN_W] = 5'd31;
                v = 1'b0; h = '1; w = '1;
                e = '0;
                tg = "R9";
            end else if (j < NVEC + NBUB + NRAND) begin
                bit narrow = ($urandom_range(0, 1) == 1);
                for (int i = 0; i < LANES; i++)
                    lens[i*LEN_W +: LEN_W] = narrow ? LEN_W'($urandom_range(2, 6))
                                                    : LEN_W'($urandom_range(0, 31));
                v = ($urandom_range(0, 7) != 0);
                h = LANES'($urandom) | LANES'($urandom);
                w = LANES'($urandom) | LANES'($urandom);
                e = ref_pick(v, h, w, lens, j);
                tg = "R3";
            end else begin
                lens = '0;
                v = 1'b0; h = '0; w = '0;
                e = '0;
                tg = "R2";
            end
            drive(v, h, w, lens, j);
            exp_r[j % 8]   = e;
            exp_tag[j % 8] = tg;
        end

        // mid-stream reset flushes the tree
        @(negedge clk);
        for (int i = 0; i < LANES; i++) lens[i*LEN_W +: LEN_W] = 5'd20;
        drive(1'b1, '1, '1, lens, 1);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(zero_r, "R1");
        @(negedge clk);
        drive(1'b0, '0, '0, '0, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(zero_r, "R1");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule